// File: doc/BRIEF.md
# Flagged Character Input/Output Port

This block is the accumulator-side character port of a 16-bit hardwired processor. It holds one 8-bit receive byte, one 8-bit transmit byte, a flag for each, and an interrupt-enable bit. A device side pushes received bytes in with a valid strobe and removes transmitted bytes with a take strobe. The processor side presents the instruction word and the accumulator in its execute step. When the instruction is an I/O instruction, the block returns a new accumulator value, a request to skip the next instruction, or an update to its own state.

The two flags have opposite senses. The receive flag is 1 while a byte is waiting to be read. The transmit flag is 1 while the transmit byte is free. A received byte enters the accumulator zero-extended. The interrupt request combines the enable bit with both flags, so software can poll the flags or wait for the interrupt. Accumulator and skip outputs are combinational in the execute cycle. All state changes take effect at the clock edge that closes that cycle.

Top module: `chario_port`

## Requirements
- R1: An instruction acts only when exec_i is 1, instr_i[15] is 1 and instr_i[14:12] is 3'b111. In any other cycle ac_wr_o and skip_o stay 0 and no flag, byte or enable changes. Within an I/O instruction the operation selects are bit 11 (read byte), bit 10 (write byte), bit 9 (skip if receive flag), bit 8 (skip if transmit flag), bit 7 (interrupts on) and bit 6 (interrupts off).
- R2: A rx_valid_i pulse while the receive flag is 0 stores rx_data_i, and rx_ready_o is 1 from the next cycle.
- R3: A read-byte instruction drives ac_wr_o=1 and ac_o={8'h00, stored byte} in its execute cycle, and clears rx_ready_o at the following edge.
- R4: A byte that arrives while rx_ready_o is 1, with no read in the same cycle, is dropped. The stored byte is kept and rx_overrun_o becomes 1 and stays 1 until reset.
- R5: After reset, rx_ready_o=0, tx_empty_o=1, irq_en_o=0, rx_overrun_o=0 and irq_o=0.
- R6: A write-byte instruction copies ac_i[7:0] to tx_data_o and clears tx_empty_o at the following edge.
- R7: A tx_take_i pulse while tx_empty_o is 0 sets tx_empty_o to 1. While tx_empty_o is 1 the pulse has no effect. If a write-byte and a take fall in the same cycle, the write wins.
- R8: In the execute cycle, skip_o is 1 when bit 9 is selected and rx_ready_o is 1, or when bit 8 is selected and tx_empty_o is 1. Otherwise skip_o is 0.
- R9: Interrupts-on sets irq_en_o at the next edge and interrupts-off clears it. When both bits are selected, off wins.
- R10: irq_o is 1 exactly when irq_en_o is 1 and either rx_ready_o or tx_empty_o is 1.
- R11: A byte arriving in the same cycle as a read-byte instruction is stored, rx_ready_o stays 1, and no overrun is recorded. The read returns the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute step for the instruction on instr_i |
| instr_i | input | 16 | Instruction word |
| ac_i | input | 16 | Current accumulator value |
| ac_wr_o | output | 1 | Load ac_o into the accumulator this cycle |
| ac_o | output | 16 | New accumulator value (zero-extended byte) |
| skip_o | output | 1 | Request to skip the next instruction |
| irq_o | output | 1 | Interrupt request |
| irq_en_o | output | 1 | Interrupt enable state |
| rx_valid_i | input | 1 | Device delivers a byte this cycle |
| rx_data_i | input | 8 | Delivered byte |
| rx_ready_o | output | 1 | Receive flag: byte waiting |
| rx_overrun_o | output | 1 | Sticky dropped-byte indication |
| tx_data_o | output | 8 | Byte offered to the device |
| tx_empty_o | output | 1 | Transmit flag: transmit byte free |
| tx_take_i | input | 1 | Device accepts the offered byte |

## Verification
The assertions assume that exec_i, rx_valid_i and tx_take_i are single-cycle strobes sampled at the rising edge. They also assume that the device reads tx_data_o only while tx_empty_o is 0. The stimulus changes every input just after a rising edge and clears each strobe one edge later, so each strobe covers exactly one edge. The cases where events fall in the same cycle (read with arrival, write with take, both enable bits) are driven on purpose in one cycle. All other scenarios keep device and processor events in separate cycles.

// File: rtl/chario_pkg.sv
package chario_pkg;
  localparam int unsigned INSTR_W   = 16;
  localparam int unsigned IND_BIT   = 15;
  localparam int unsigned OPC_HI    = 14;
  localparam int unsigned OPC_LO    = 12;
  localparam logic [2:0]  OPC_IO    = 3'b111;
  localparam int unsigned SEL_READ  = 11;
  localparam int unsigned SEL_WRITE = 10;
  localparam int unsigned SEL_SKRX  = 9;
  localparam int unsigned SEL_SKTX  = 8;
  localparam int unsigned SEL_ION   = 7;
  localparam int unsigned SEL_IOFF  = 6;

  typedef struct packed {
    logic read_byte;
    logic write_byte;
    logic skip_rx;
    logic skip_tx;
    logic irq_on;
    logic irq_off;
  } io_ops_t;
endpackage

// File: rtl/chario_decode.sv
module chario_decode
  import chario_pkg::*;
(
  input  logic               exec_i,
  input  logic [INSTR_W-1:0] instr_i,
  output io_ops_t            ops_o
);
  logic hit;
  logic unused_low_bits;

  assign hit = exec_i && instr_i[IND_BIT] && (instr_i[OPC_HI:OPC_LO] == OPC_IO);
  assign unused_low_bits = ^instr_i[SEL_IOFF-1:0];

  always_comb begin
    ops_o            = '0;
    ops_o.read_byte  = hit & instr_i[SEL_READ];
    ops_o.write_byte = hit & instr_i[SEL_WRITE];
    ops_o.skip_rx    = hit & instr_i[SEL_SKRX];
    ops_o.skip_tx    = hit & instr_i[SEL_SKTX];
    ops_o.irq_on     = hit & instr_i[SEL_ION];
    ops_o.irq_off    = hit & instr_i[SEL_IOFF];
  end
endmodule

// File: rtl/chario_rx.sv
module chario_rx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arrive_i,
  input  logic [DW-1:0] data_i,
  input  logic          take_i,
  output logic          full_o,
  output logic [DW-1:0] data_o,
  output logic          overrun_o
);
  logic accept;
  logic drop;

  // a read in the same cycle frees the slot for the arriving byte
  assign accept = arrive_i && (!full_o || take_i);
  assign drop   = arrive_i && full_o && !take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o    <= 1'b0;
      data_o    <= '0;
      overrun_o <= 1'b0;
    end else begin
      if (accept) begin
        full_o <= 1'b1;
        data_o <= data_i;
      end else if (take_i) begin
        full_o <= 1'b0;
      end
      if (drop) overrun_o <= 1'b1;
    end
  end

  AST_RX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arrive_i && !full_o |=> full_o && data_o == $past(data_i)); // R2
  AST_RX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !arrive_i |=> !full_o); // R3
  AST_RX_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arrive_i && full_o && !take_i |=> overrun_o && $stable(data_o)); // R4
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o); // R4
  AST_RX_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arrive_i && take_i |=> full_o && data_o == $past(data_i)); // R11
endmodule

// File: rtl/chario_tx.sv
module chario_tx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          put_i,
  input  logic [DW-1:0] put_data_i,
  input  logic          drain_i,
  output logic          empty_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_o <= 1'b1;
      data_o  <= '0;
    end else if (put_i) begin
      empty_o <= 1'b0;
      data_o  <= put_data_i;
    end else if (drain_i && !empty_o) begin
      empty_o <= 1'b1;
    end
  end

  AST_TX_PUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    put_i |=> !empty_o && data_o == $past(put_data_i)); // R6
  AST_TX_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_i && !put_i |=> empty_o); // R7
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !put_i |=> $stable(data_o)); // R7
endmodule

// File: rtl/chario_irq.sv
module chario_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic off_i,
  input  logic rx_full_i,
  input  logic tx_empty_i,
  output logic en_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_o <= 1'b0;
    else if (off_i)  en_o <= 1'b0;
    else if (on_i)   en_o <= 1'b1;
  end

  assign irq_o = en_o & (rx_full_i | tx_empty_i);

  AST_IEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i |=> !en_o); // R9
  AST_IEN_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_i && !off_i |=> en_o); // R9
endmodule

// File: rtl/chario_port.sv
module chario_port
  import chario_pkg::*;
#(
  parameter int unsigned AC_W = 16,
  parameter int unsigned DW   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exec_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [AC_W-1:0]    ac_i,
  output logic               ac_wr_o,
  output logic [AC_W-1:0]    ac_o,
  output logic               skip_o,
  output logic               irq_o,
  output logic               irq_en_o,
  input  logic               rx_valid_i,
  input  logic [DW-1:0]      rx_data_i,
  output logic               rx_ready_o,
  output logic               rx_overrun_o,
  output logic [DW-1:0]      tx_data_o,
  output logic               tx_empty_o,
  input  logic               tx_take_i
);
  localparam int unsigned PAD_W = AC_W - DW;

  io_ops_t       ops;
  logic [DW-1:0] rx_byte;
  logic          unused_ac_high;

  assign unused_ac_high = ^ac_i[AC_W-1:DW];

  chario_decode u_dec (
    .exec_i (exec_i),
    .instr_i(instr_i),
    .ops_o  (ops)
  );

  chario_rx #(.DW(DW)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arrive_i (rx_valid_i),
    .data_i   (rx_data_i),
    .take_i   (ops.read_byte),
    .full_o   (rx_ready_o),
    .data_o   (rx_byte),
    .overrun_o(rx_overrun_o)
  );

  chario_tx #(.DW(DW)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .put_i     (ops.write_byte),
    .put_data_i(ac_i[DW-1:0]),
    .drain_i   (tx_take_i),
    .empty_o   (tx_empty_o),
    .data_o    (tx_data_o)
  );

  chario_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .on_i      (ops.irq_on),
    .off_i     (ops.irq_off),
    .rx_full_i (rx_ready_o),
    .tx_empty_i(tx_empty_o),
    .en_o      (irq_en_o),
    .irq_o     (irq_o)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign ac_o = {{PAD_W{1'b0}}, rx_byte};
    end else begin : g_nopad
      assign ac_o = rx_byte;
    end
  endgenerate

  assign ac_wr_o = ops.read_byte;
  assign skip_o  = (ops.skip_rx & rx_ready_o) | (ops.skip_tx & tx_empty_o);

  AST_NO_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec_i && instr_i[IND_BIT]) |-> !ac_wr_o && !skip_o); // R1
  AST_IDLE_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i && !rx_valid_i && !tx_take_i |=>
      $stable(rx_ready_o) && $stable(tx_empty_o) && $stable(irq_en_o)); // R1
  AST_ZERO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ac_wr_o |-> ac_o[AC_W-1:DW] == '0); // R3
  AST_SKIP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |-> !skip_o); // R8
endmodule

// File: tb/sim_chario_port.sv
`timescale 1ns/1ps
module sim_chario_port;
  localparam logic [15:0] I_READ  = 16'hF800;
  localparam logic [15:0] I_WRITE = 16'hF400;
  localparam logic [15:0] I_SKRX  = 16'hF200;
  localparam logic [15:0] I_SKTX  = 16'hF100;
  localparam logic [15:0] I_ION   = 16'hF080;
  localparam logic [15:0] I_IOFF  = 16'hF040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] ac = '0;
  logic        ac_wr, skip, irq, irq_en;
  logic [15:0] ac_new;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, rx_ovr;
  logic [7:0]  tx_data;
  logic        tx_empty;
  logic        tx_take = 1'b0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  chario_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .instr_i(instr), .ac_i(ac),
    .ac_wr_o(ac_wr), .ac_o(ac_new), .skip_o(skip), .irq_o(irq), .irq_en_o(irq_en),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .rx_overrun_o(rx_ovr), .tx_data_o(tx_data), .tx_empty_o(tx_empty),
    .tx_take_i(tx_take)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one edge, then drop every strobe
  task automatic step();
    @(posedge clk);
    #2;
    exec = 1'b0; rx_valid = 1'b0; tx_take = 1'b0; instr = '0;
  endtask

  task automatic issue(input logic [15:0] ins, input logic [15:0] acc);
    exec = 1'b1; instr = ins; ac = acc; #1;
  endtask

  task automatic deliver(input logic [7:0] d);
    rx_valid = 1'b1; rx_data = d;
  endtask

  task automatic t_reset();
    check(rx_ready, 0, "R5 rx_ready");
    check(tx_empty, 1, "R5 tx_empty");
    check(irq_en,   0, "R5 irq_en");
    check(rx_ovr,   0, "R5 overrun");
    check(irq,      0, "R5 irq");
  endtask

  task automatic t_receive();
    deliver(8'hA5); step();
    check(rx_ready, 1, "R2 flag set");
    issue(I_SKRX, 0);
    check(skip, 1, "R8 skip on rx flag");
    step();
  endtask

  task automatic t_overrun();
    deliver(8'h3C); step();
    check(rx_ovr, 1, "R4 overrun set");
    check(rx_ready, 1, "R4 flag kept");
    issue(I_READ, 16'hFFFF);
    check(ac_wr, 1, "R3 ac write");
    check(ac_new, 16'h00A5, "R3 R4 zero-extended old byte");
    step();
    check(rx_ready, 0, "R3 flag cleared");
    check(rx_ovr, 1, "R4 overrun sticky");
    issue(I_SKRX, 0);
    check(skip, 0, "R8 no skip rx empty");
    step();
  endtask

  task automatic t_decode();
    deliver(8'h5A); step();
    issue(16'h7800, 0);
    check(ac_wr, 0, "R1 indirect bit clear");
    step();
    issue(16'hE800, 0);
    check(ac_wr, 0, "R1 wrong opcode");
    step();
    instr = I_READ; #1;
    check(ac_wr, 0, "R1 no exec");
    step();
    check(rx_ready, 1, "R1 state untouched");
    issue(16'h7100, 0);
    check(skip, 0, "R1 no skip outside io");
    step();
  endtask

  task automatic t_same_cycle();
    issue(I_READ, 0);
    deliver(8'h77);
    check(ac_new, 16'h005A, "R11 read returns previous");
    step();
    check(rx_ready, 1, "R11 flag stays set");
    issue(I_READ, 0);
    check(ac_new, 16'h0077, "R11 new byte stored");
    step();
    check(rx_ready, 0, "R3 cleared after read");
  endtask

  task automatic t_transmit();
    issue(I_SKTX, 0);
    check(skip, 1, "R8 skip on tx empty");
    step();
    issue(I_WRITE, 16'h12C3); step();
    check(tx_empty, 0, "R6 flag cleared");
    check(tx_data, 16'h00C3, "R6 low byte");
    issue(I_SKTX, 0);
    check(skip, 0, "R8 no skip tx busy");
    step();
    tx_take = 1'b1; step();
    check(tx_empty, 1, "R7 take sets flag");
    tx_take = 1'b1; step();
    check(tx_empty, 1, "R7 take while empty ignored");
    check(tx_data, 16'h00C3, "R7 data unchanged");
    issue(I_WRITE, 16'h0044); tx_take = 1'b1; step();
    check(tx_empty, 0, "R7 write wins over take");
    check(tx_data, 16'h0044, "R7 new data");
    tx_take = 1'b1; step();
  endtask

  task automatic t_irq();
    check(irq, 0, "R10 disabled");
    issue(I_ION, 0); step();
    check(irq_en, 1, "R9 on");
    check(irq, 1, "R10 tx empty");
    issue(I_WRITE, 16'h0011); step();
    check(irq, 0, "R10 no flag");
    deliver(8'h01); step();
    check(irq, 1, "R10 rx flag");
    issue(16'hF0C0, 0); step();
    check(irq_en, 0, "R9 off wins");
    check(irq, 0, "R10 disabled again");
    issue(I_ION, 0); step();
    issue(I_IOFF, 0); step();
    check(irq_en, 0, "R9 off");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_receive();
    t_overrun();
    t_decode();
    t_same_cycle();
    t_transmit();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule